// File: doc/BRIEF.md
# Ping-Pong Frame Capture Address Engine

This block sits between a camera pixel stream, already packed into 8-byte words, and a memory write port. Each frame goes to one of two frame buffers, chosen in strict alternation. The buffer is picked on the first word of the frame. If a frame is cut short, the next start-of-frame still lands cleanly on a buffer base. For every word the block produces a byte address. It adds a programmable gap of whole words at the end of each line, so that a frame can sit inside a wider surface. It also marks the start of each burst and the length of that burst. The burst size is chosen from the number of bytes in a line.

When a frame completes, a sticky done flag for the buffer just filled is raised, and a frame counter advances. Software clears the flags by writing 1 to them. A reflash pulse forces the next frame back to buffer 0. The configuration inputs are register-style levels. The two base addresses are sampled at frame start.

Top module: `cap_pingpong_dma`

## Requirements
- R1: After reset, `wr_valid` is 0, `done_flags` is 2'b00 and `frame_count` is 0.
- R2: The first frame after reset is written to buffer 0. Every later start-of-frame selects the other buffer from the previous one: buffer 0 uses `cfg_base0`, buffer 1 uses `cfg_base1`.
- R3: A `cfg_reflash` pulse, at or before a start-of-frame word, makes that frame use buffer 0 whatever the alternation state. Alternation then resumes from buffer 0.
- R4: The number of words in a line is L. The byte address of the word at row r and column c is base + 8*(r*(L + cfg_stride) + c), where `cfg_stride` counts 8-byte words. The address appears on `wr_addr` with `wr_valid` in the cycle after the word is accepted.
- R5: The burst size B is 16 if the line byte count is divisible by 128, else 8 if it is divisible by 64, else 4. `wr_first` is 1 on words whose column is a multiple of B. `wr_len` equals min(B, L - column) on every word.
- R6: A start-of-frame word arriving inside a frame abandons that frame. No done flag or count is given for it, and the new frame starts at the next buffer's base.
- R7: One cycle after the last word of the last line appears on the write port, bit b of `done_flags` is set, where b is the buffer filled (bit 0 = buffer 0, bit 1 = buffer 1). The flag stays set until 1 is written to the same bit of `done_clr`. A set in the same cycle as a clear wins.
- R8: If both buffers have completed and neither flag is cleared, `done_flags` reads 2'b11.
- R9: A change to a base input during a frame does not move that frame. The new value is used by the next frame that selects that buffer.
- R10: `frame_count` increments one cycle after each completed frame, and a `cfg_cnt_clr` pulse sets it to 0. If both happen in the same cycle, the clear wins.
- R11: Valid words outside a frame (after completion or abandonment, before a start-of-frame) produce no write.
- R12: `cfg_width` counts camera bus cycles per line. The line byte count is `cfg_width` times BUS_BYTES (2 by default), and L is that count divided by 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base0 | input | AW | Byte base address of buffer 0 (8-byte aligned) |
| cfg_base1 | input | AW | Byte base address of buffer 1 (8-byte aligned) |
| cfg_width | input | WW | Bus cycles per line |
| cfg_height | input | HW | Lines per frame |
| cfg_stride | input | SW | Words skipped after each line |
| cfg_reflash | input | 1 | Pulse: next frame uses buffer 0 |
| cfg_cnt_clr | input | 1 | Pulse: clear the frame counter |
| px_valid | input | 1 | Pixel word valid |
| px_sof | input | 1 | Word is the first of a frame |
| px_data | input | 64 | Pixel word |
| wr_valid | output | 1 | Write word valid |
| wr_first | output | 1 | Word starts a burst |
| wr_len | output | 5 | Burst length in words |
| wr_addr | output | AW | Byte address of the word |
| wr_data | output | 64 | Word data |
| done_clr | input | 2 | Write-1-to-clear for the done flags |
| done_flags | output | 2 | Sticky per-buffer frame done flags |
| frame_count | output | FCW | Completed frame counter |

## Verification
The main function is tried with three line geometries: 128-byte lines with a 2-word stride, 64-byte lines with no gaps, and 40-byte lines. Together they cover each burst size and the short final burst of the 4-word case. Frames are sent both with periodic invalid gaps and without gaps, which separates word counting from cycle counting. Alternation is probed with frame sequences that include a reflash, an abandoned frame and a base change during a frame, and each of these moves the start address differently. Stray valid words between frames, flag clears and counter clears check that idle input is ignored and that the status paths are independent of the address path.

// File: rtl/cap_pkg.sv
package cap_pkg;
   localparam int unsigned WORD_SHIFT = 3;
   localparam int unsigned BLEN_W     = 5;

   typedef struct packed {
      logic done;
      logic buf_id;
   } cmpl_t;

   function automatic logic [BLEN_W-1:0] pick_burst(input logic [6:0] low);
      if (low == 7'd0)           return 5'd16;
      else if (low[5:0] == 6'd0) return 5'd8;
      else                       return 5'd4;
   endfunction
endpackage

// File: rtl/cap_line_bytes.sv
module cap_line_bytes #(
   parameter int unsigned WW        = 12,
   parameter int unsigned BUS_BYTES = 2,
   parameter int unsigned LBW       = WW + 2
) (
   input  logic [WW-1:0]  width,
   output logic [LBW-1:0] bytes
);
   generate
      if (BUS_BYTES == 1) begin : g_b1
         assign bytes = LBW'(width);
      end else if (BUS_BYTES == 2) begin : g_b2
         assign bytes = LBW'({width, 1'b0});
      end else begin : g_b4
         assign bytes = LBW'({width, 2'b00});
      end
   endgenerate
endmodule

// File: rtl/cap_burst_sel.sv
module cap_burst_sel #(
   parameter int unsigned LBW = 14
) (
   input  logic [LBW-1:0]             line_bytes,
   output logic [cap_pkg::BLEN_W-1:0] blen
);
   logic unused_hi;
   assign unused_hi = ^line_bytes[LBW-1:7];
   assign blen = cap_pkg::pick_burst(line_bytes[6:0]);
endmodule

// File: rtl/cap_addr_gen.sv
module cap_addr_gen #(
   parameter int unsigned AW  = 32,
   parameter int unsigned HW  = 12,
   parameter int unsigned SW  = 12,
   parameter int unsigned LWW = 11
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [AW-1:0]              base0,
   input  logic [AW-1:0]              base1,
   input  logic [LWW-1:0]             line_words,
   input  logic [HW-1:0]              height,
   input  logic [SW-1:0]              stride,
   input  logic [cap_pkg::BLEN_W-1:0] blen,
   input  logic                       reflash,
   input  logic                       px_valid,
   input  logic                       px_sof,
   input  logic [63:0]                px_data,
   output logic                       wr_valid,
   output logic                       wr_first,
   output logic [cap_pkg::BLEN_W-1:0] wr_len,
   output logic [AW-1:0]              wr_addr,
   output logic [63:0]                wr_data,
   output cap_pkg::cmpl_t             cmpl
);
   localparam int unsigned WAW = AW - cap_pkg::WORD_SHIFT;

   logic           active_q, last_buf_q, pend_q;
   logic [LWW-1:0] col_q;
   logic [HW-1:0]  row_q;
   logic [WAW-1:0] rbase_q;

   logic           start, take, buf_now, end_line, end_frame, first_now;
   logic [WAW-1:0] rbase_now;
   logic [LWW-1:0] col_now, remain, blen_x;
   logic [HW-1:0]  row_now;
   logic [cap_pkg::BLEN_W-1:0] len_now;
   logic           unused_lo;

   assign unused_lo = ^{base0[2:0], base1[2:0]};

   always_comb begin
      start     = px_valid && px_sof;
      take      = px_valid && (px_sof || active_q);
      buf_now   = start ? (~(pend_q | reflash) & ~last_buf_q) : last_buf_q;
      rbase_now = start ? (buf_now ? base1[AW-1:cap_pkg::WORD_SHIFT]
                                   : base0[AW-1:cap_pkg::WORD_SHIFT]) : rbase_q;
      col_now   = start ? '0 : col_q;
      row_now   = start ? '0 : row_q;
      end_line  = (col_now == line_words - LWW'(1));
      end_frame = end_line && (row_now == height - HW'(1));
      blen_x    = LWW'(blen);
      remain    = line_words - col_now;
      len_now   = (remain < blen_x) ? remain[cap_pkg::BLEN_W-1:0] : blen;
      first_now = ((col_now & (blen_x - LWW'(1))) == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         last_buf_q <= 1'b1;
         pend_q     <= 1'b0;
         col_q      <= '0;
         row_q      <= '0;
         rbase_q    <= '0;
         wr_valid   <= 1'b0;
         wr_first   <= 1'b0;
         wr_len     <= '0;
         wr_addr    <= '0;
         wr_data    <= '0;
         cmpl       <= '0;
      end else begin
         wr_valid    <= take;
         cmpl.done   <= take && end_frame;
         cmpl.buf_id <= buf_now;
         pend_q      <= start ? 1'b0 : (pend_q | reflash);
         if (take) begin
            wr_first   <= first_now;
            wr_len     <= len_now;
            wr_addr    <= {rbase_now + WAW'(col_now), 3'b000};
            wr_data    <= px_data;
            last_buf_q <= buf_now;
            if (end_line) begin
               col_q    <= '0;
               row_q    <= row_now + HW'(1);
               rbase_q  <= rbase_now + WAW'(line_words) + WAW'(stride);
               active_q <= ~end_frame;
            end else begin
               col_q    <= col_now + LWW'(1);
               row_q    <= row_now;
               rbase_q  <= rbase_now;
               active_q <= 1'b1;
            end
         end
      end
   end

   p_sof_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (wr_valid && wr_first && (wr_addr[2:0] == 3'b000)));
   p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> ((wr_len != '0) && (wr_len <= 5'd16)));
   p_idle_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !start) |=> !wr_valid);
   p_reflash_buf0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && reflash) |=> !last_buf_q);
   p_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !reflash && !pend_q) |=> (last_buf_q != $past(last_buf_q)));
endmodule

// File: rtl/cap_status.sv
module cap_status #(
   parameter int unsigned FCW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  cap_pkg::cmpl_t cmpl,
   input  logic [1:0]     done_clr,
   input  logic           cnt_clr,
   output logic [1:0]     done_flags,
   output logic [FCW-1:0] frame_count
);
   logic [1:0] set_v;
   assign set_v = cmpl.done ? (cmpl.buf_id ? 2'b10 : 2'b01) : 2'b00;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) done_flags[g] <= 1'b0;
            else        done_flags[g] <= set_v[g] | (done_flags[g] & ~done_clr[g]);
         end
         p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (done_flags[g] && !done_clr[g]) |=> done_flags[g]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       frame_count <= '0;
      else if (cnt_clr) frame_count <= '0;
      else              frame_count <= frame_count + FCW'(cmpl.done);
   end

   p_set_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl.done |=> done_flags[$past(cmpl.buf_id)]);
   p_cnt_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> (frame_count == '0));
endmodule

// File: rtl/cap_pingpong_dma.sv
module cap_pingpong_dma #(
   parameter int unsigned AW        = 32,
   parameter int unsigned WW        = 12,
   parameter int unsigned HW        = 12,
   parameter int unsigned SW        = 12,
   parameter int unsigned FCW       = 16,
   parameter int unsigned BUS_BYTES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  cfg_base0,
   input  logic [AW-1:0]  cfg_base1,
   input  logic [WW-1:0]  cfg_width,
   input  logic [HW-1:0]  cfg_height,
   input  logic [SW-1:0]  cfg_stride,
   input  logic           cfg_reflash,
   input  logic           cfg_cnt_clr,
   input  logic           px_valid,
   input  logic           px_sof,
   input  logic [63:0]    px_data,
   output logic           wr_valid,
   output logic           wr_first,
   output logic [4:0]     wr_len,
   output logic [AW-1:0]  wr_addr,
   output logic [63:0]    wr_data,
   input  logic [1:0]     done_clr,
   output logic [1:0]     done_flags,
   output logic [FCW-1:0] frame_count
);
   localparam int unsigned LBW = WW + 2;
   localparam int unsigned LWW = LBW - cap_pkg::WORD_SHIFT;

   initial begin
      a_bus_bytes: assert (BUS_BYTES == 1 || BUS_BYTES == 2 || BUS_BYTES == 4)
         else $fatal(1, "BUS_BYTES must be 1, 2 or 4");
      a_width_min: assert (WW >= 6) else $fatal(1, "WW too small");
      a_addr_room: assert (AW - cap_pkg::WORD_SHIFT > LWW && AW - cap_pkg::WORD_SHIFT >= SW)
         else $fatal(1, "AW too small for line and stride");
   end

   logic [LBW-1:0]             line_bytes;
   logic [cap_pkg::BLEN_W-1:0] blen;
   cap_pkg::cmpl_t             cmpl;
   logic                       unused_lb;

   assign unused_lb = ^line_bytes[2:0];

   cap_line_bytes #(.WW(WW), .BUS_BYTES(BUS_BYTES), .LBW(LBW)) u_lb (
      .width(cfg_width), .bytes(line_bytes));

   cap_burst_sel #(.LBW(LBW)) u_bs (.line_bytes(line_bytes), .blen(blen));

   cap_addr_gen #(.AW(AW), .HW(HW), .SW(SW), .LWW(LWW)) u_ag (
      .clk(clk), .rst_n(rst_n), .base0(cfg_base0), .base1(cfg_base1),
      .line_words(line_bytes[LBW-1:cap_pkg::WORD_SHIFT]), .height(cfg_height),
      .stride(cfg_stride), .blen(blen), .reflash(cfg_reflash),
      .px_valid(px_valid), .px_sof(px_sof), .px_data(px_data),
      .wr_valid(wr_valid), .wr_first(wr_first), .wr_len(wr_len),
      .wr_addr(wr_addr), .wr_data(wr_data), .cmpl(cmpl));

   cap_status #(.FCW(FCW)) u_st (
      .clk(clk), .rst_n(rst_n), .cmpl(cmpl), .done_clr(done_clr),
      .cnt_clr(cfg_cnt_clr), .done_flags(done_flags), .frame_count(frame_count));
endmodule

// File: tb/sim_cap_pingpong_dma.sv
module sim_cap_pingpong_dma;
   localparam int AW = 32, WW = 12, HW = 12, SW = 12, FCW = 16, BB = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [AW-1:0] cfg_base0, cfg_base1;
   logic [WW-1:0] cfg_width;
   logic [HW-1:0] cfg_height;
   logic [SW-1:0] cfg_stride;
   logic cfg_reflash = 0, cfg_cnt_clr = 0, px_valid = 0, px_sof = 0;
   logic [63:0] px_data = '0;
   logic [1:0] done_clr = '0;
   logic wr_valid, wr_first;
   logic [4:0] wr_len;
   logic [AW-1:0] wr_addr;
   logic [63:0] wr_data;
   logic [1:0] done_flags;
   logic [FCW-1:0] frame_count;

   cap_pingpong_dma #(.AW(AW), .WW(WW), .HW(HW), .SW(SW), .FCW(FCW), .BUS_BYTES(BB)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_base0(cfg_base0), .cfg_base1(cfg_base1),
      .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_stride(cfg_stride),
      .cfg_reflash(cfg_reflash), .cfg_cnt_clr(cfg_cnt_clr), .px_valid(px_valid),
      .px_sof(px_sof), .px_data(px_data), .wr_valid(wr_valid), .wr_first(wr_first),
      .wr_len(wr_len), .wr_addr(wr_addr), .wr_data(wr_data), .done_clr(done_clr),
      .done_flags(done_flags), .frame_count(frame_count));

   int n_cmp = 0, n_bad = 0;
   task automatic chk(string tag, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   bit m_active = 0, m_pend = 0, p_cmpl = 0, e_valid = 0, e_first = 0, e_start = 0;
   int m_last = 1, m_buf = 0, p_buf = 0, m_row = 0, m_col = 0, e_len = 0, m_cnt = 0;
   logic [31:0] m_base = 0, e_addr = 0;
   logic [63:0] e_data = 0;
   logic [1:0] m_done = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_active = 0; m_pend = 0; p_cmpl = 0; e_valid = 0; m_last = 1;
         m_done = 0; m_cnt = 0; e_start = 0;
      end else begin
         int lw, bl, lb;
         bit sof_taken;
         m_done = m_done & ~done_clr;
         if (p_cmpl) m_done[p_buf] = 1'b1;
         if (cfg_cnt_clr) m_cnt = 0; else if (p_cmpl) m_cnt++;
         p_cmpl = 0; e_valid = 0; e_start = 0; sof_taken = 0;
         if (px_valid && (px_sof || m_active)) begin
            if (px_sof) begin
               m_buf = (cfg_reflash || m_pend) ? 0 : 1 - m_last;
               m_pend = 0; m_last = m_buf; sof_taken = 1;
               m_base = (m_buf == 1) ? cfg_base1 : cfg_base0;
               m_base[2:0] = 3'b000;
               m_row = 0; m_col = 0; m_active = 1; e_start = 1;
            end
            lb = int'(cfg_width) * BB;
            lw = lb / 8;
            bl = (lb % 128 == 0) ? 16 : (lb % 64 == 0) ? 8 : 4;
            e_valid = 1;
            e_addr = m_base + 32'((m_row * (lw + int'(cfg_stride)) + m_col) * 8);
            e_data = px_data;
            e_first = (m_col % bl == 0);
            e_len = (lw - m_col < bl) ? lw - m_col : bl;
            if (m_col == lw - 1) begin
               m_col = 0; m_row++;
               if (m_row == int'(cfg_height)) begin m_active = 0; p_cmpl = 1; p_buf = m_buf; end
            end else m_col++;
         end
         if (cfg_reflash && !sof_taken) m_pend = 1;
      end
   end

   logic [31:0] obs_start = 0, obs_line2 = 0;
   int obs_words = 0, stray_writes = 0;
   bit cmp_on = 0;

   always @(negedge clk) if (cmp_on) begin
      chk("R11 wr_valid", wr_valid, e_valid);
      if (e_valid) begin
         chk("R4 wr_addr", wr_addr, e_addr);
         chk("R5 wr_first", wr_first, e_first);
         chk("R5 wr_len", wr_len, e_len);
         chk("R4 wr_data", wr_data, e_data);
      end
      chk("R7 done_flags", done_flags, m_done);
      chk("R10 frame_count", frame_count, m_cnt);
      if (wr_valid) begin
         if (e_start) begin obs_start = wr_addr; obs_words = 0; end
         obs_words++;
         if (obs_words == 17) obs_line2 = wr_addr;
      end
   end

   task automatic tick();
      @(negedge clk);
      px_valid = 0; px_sof = 0; cfg_reflash = 0; cfg_cnt_clr = 0; done_clr = 0;
   endtask

   task automatic frame(int total, int gap, int chg_at, logic [31:0] chg_val);
      int sent = 0;
      for (int k = 0; sent < total; k++) begin
         tick();
         if (gap != 0 && (k % gap) == gap - 1) continue;
         px_valid = 1; px_sof = (sent == 0);
         px_data = {32'hCAFE0000 + 32'(sent), 32'(k)};
         if (sent == chg_at) cfg_base1 = chg_val;
         sent++;
      end
      tick(); tick(); tick();
   endtask

   bit finished = 0;
   initial begin
      #(20ns * 150000);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      cfg_base0 = 32'h0000_1000; cfg_base1 = 32'h0004_0000;
      cfg_width = 64; cfg_height = 3; cfg_stride = 2;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset wr_valid", wr_valid, 0);
      chk("R1 reset done", done_flags, 0);
      chk("R1 reset count", frame_count, 0);
      cmp_on = 1;
      // 128-byte lines, stride 2, gaps
      frame(48, 3, -1, 0);
      chk("R2 first frame buffer0", obs_start, 32'h1000);
      chk("R4 line2 after stride", obs_line2, 32'h1090);
      chk("R7 done buffer0", done_flags, 2'b01);
      // 64-byte lines
      cfg_width = 32; cfg_height = 2; cfg_stride = 0;
      frame(16, 0, -1, 0);
      chk("R2 second frame buffer1", obs_start, 32'h4_0000);
      chk("R8 both flags", done_flags, 2'b11);
      tick(); done_clr = 2'b01; tick();
      chk("R7 clear bit0", done_flags, 2'b10);
      done_clr = 2'b10; tick(); tick();
      chk("R7 clear bit1", done_flags, 2'b00);
      // 40-byte lines, burst 4 with tail
      cfg_width = 20; cfg_height = 2;
      frame(10, 0, -1, 0);
      chk("R12 words per frame", obs_words, 10);
      chk("R5 short-line frame buffer0", obs_start, 32'h1000);
      // reflash
      tick(); cfg_reflash = 1; tick();
      frame(10, 2, -1, 0);
      chk("R3 reflash forces buffer0", obs_start, 32'h1000);
      tick(); done_clr = 2'b11; tick();
      // abandoned frame then full frame
      frame(3, 0, -1, 0);
      chk("R6 broken frame on buffer1", obs_start, 32'h4_0000);
      chk("R6 no done from broken", done_flags, 2'b00);
      frame(10, 0, -1, 0);
      chk("R6 next frame buffer0", obs_start, 32'h1000);
      chk("R6 only buffer0 done", done_flags, 2'b01);
      // base change mid-frame
      frame(10, 0, 4, 32'h0005_0000);
      chk("R9 mid-frame change ignored", obs_start, 32'h4_0000);
      frame(10, 0, -1, 0);
      frame(10, 0, -1, 0);
      chk("R9 new base used next time", obs_start, 32'h5_0000);
      // stray words outside a frame
      stray_writes = 0;
      for (int i = 0; i < 6; i++) begin
         tick(); px_valid = 1; px_data = 64'(i);
         @(posedge clk); #1; if (wr_valid) stray_writes++;
      end
      tick(); @(posedge clk); #1; if (wr_valid) stray_writes++;
      chk("R11 stray words ignored", stray_writes, 0);
      // counter clear
      tick(); cfg_cnt_clr = 1; tick(); tick();
      chk("R10 count cleared", frame_count, 0);
      frame(10, 0, -1, 0);
      chk("R10 count after frame", frame_count, 1);
      cmp_on = 0;
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule